// File: doc/BRIEF.md
# Bit Count Unit with Word Variants

This unit takes a 64-bit operand and returns one of three counts: the length of the run of zeros at the top end, the length of the run of zeros at the bottom end, or the number of bits that are one. Each count also has a word form. The word form looks only at the lower 32 bits and treats bit 31 as the top of the value. The count is placed at the bottom of a 64-bit result, and all bits above it are zero.

A single scan datapath and a single adder tree serve all six operations. For a leading-zero count, the operand is bit-reversed so that the same bottom-up scan can find the run. For a word form, the upper half is forced before counting: it is forced to ones in front of the scan, which caps the count at 32, and forced to zeros in front of the adder tree. The result goes through one register. A request presented with `in_valid` therefore comes back with `out_valid` on the next clock edge.

Top module: `bitcnt_unit`

## Requirements
- R1: With `in_op` = 3'b000, the result is the number of consecutive zero bits in the operand, counted from bit 63 downward.
- R2: With `in_op` = 3'b100, the result is the number of consecutive zero bits counted from bit 31 downward, within bits 31:0 only.
- R3: With `in_op` = 3'b001, the result is the number of consecutive zero bits counted from bit 0 upward.
- R4: With `in_op` = 3'b101, the result is the number of consecutive zero bits counted from bit 0 upward, within bits 31:0 only.
- R5: With `in_op` = 3'b010, the result is the number of one bits among all 64 bits. With `in_op` = 3'b110, it is the number of one bits among bits 31:0.
- R6: Every result is zero-extended, so bits 63:7 of `out_result` are always zero.
- R7: An operand whose examined bits are all zero gives 64 for the full leading and trailing counts, and 32 for the word leading and trailing counts.
- R8: For every word form (`in_op[2]` = 1), operand bits 63:32 have no effect on the result.
- R9: `out_valid` is high exactly one cycle after `in_valid` was high. After reset, `out_valid` and `out_result` are zero.
- R10: A cycle with `in_valid` low leaves `out_result` unchanged.
- R11: The reserved count kind (`in_op[1:0]` = 2'b11) gives a result of zero, in both widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | [1:0] count kind (00 leading, 01 trailing, 10 ones, 11 reserved), [2] word form |
| in_operand | input | 64 | Value to be counted |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 64 | Zero-extended count |

## Verification
A wrong bit reversal, or a sentinel in the wrong half, shows up one cycle later as a count that is off. Such errors typically push a word count above 32 or make a full count stop at 32. Operands with a single set bit at chosen positions locate that kind of fault exactly. A wrong mask in front of the adder tree shows up as a word population count that moves when only the upper half changes. A fault in the output register shows up as a strobe that does not follow the request by exactly one edge, or as a result that drifts while no request is presented.

// File: rtl/bitcnt_pkg.sv
package bitcnt_pkg;

    typedef enum logic [1:0] {
        KIND_LEAD  = 2'b00,
        KIND_TRAIL = 2'b01,
        KIND_ONES  = 2'b10,
        KIND_RSVD  = 2'b11
    } cnt_kind_e;

    typedef struct packed {
        logic       word;
        cnt_kind_e  kind;
    } cnt_op_t;

endpackage

// File: rtl/bitcnt_prep.sv
module bitcnt_prep #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] operand,
    input  logic              word,
    input  logic              reverse,
    output logic [DATA_W-1:0] scan_vec,
    output logic [DATA_W-1:0] ones_vec
);
    localparam int HIGH_W = DATA_W - WORD_W;

    logic [DATA_W-1:0] rev_full;
    logic [WORD_W-1:0] rev_word;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev_full
        assign rev_full[i] = operand[DATA_W-1-i];
    end

    for (genvar j = 0; j < WORD_W; j++) begin : g_rev_word
        assign rev_word[j] = operand[WORD_W-1-j];
    end

    always_comb begin
        if (word) begin
            scan_vec = {{HIGH_W{1'b1}}, (reverse ? rev_word : operand[WORD_W-1:0])};
            ones_vec = {{HIGH_W{1'b0}}, operand[WORD_W-1:0]};
        end else begin
            scan_vec = reverse ? rev_full : operand;
            ones_vec = operand;
        end
    end
endmodule

// File: rtl/bitcnt_tzc.sv
module bitcnt_tzc #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] vec,
    output logic [CNT_W-1:0]  count
);
    always_comb begin
        count = CNT_W'(DATA_W);
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                count = CNT_W'(i);
            end
        end
    end
endmodule

// File: rtl/bitcnt_popc.sv
module bitcnt_popc #(
    parameter int DATA_W  = 64,
    parameter int GROUP_W = 8,
    parameter int CNT_W   = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] vec,
    output logic [CNT_W-1:0]  count
);
    localparam int NGRP   = DATA_W / GROUP_W;
    localparam int GCNT_W = $clog2(GROUP_W) + 1;

    logic [GCNT_W-1:0] grp_cnt [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        always_comb begin
            grp_cnt[g] = '0;
            for (int b = 0; b < GROUP_W; b++) begin
                grp_cnt[g] = grp_cnt[g] + GCNT_W'(vec[g*GROUP_W+b]);
            end
        end
    end

    always_comb begin
        count = '0;
        for (int g = 0; g < NGRP; g++) begin
            count = count + CNT_W'(grp_cnt[g]);
        end
    end
endmodule

// File: rtl/bitcnt_unit.sv
module bitcnt_unit #(
    parameter int DATA_W  = 64,
    parameter int WORD_W  = 32,
    parameter int GROUP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [DATA_W-1:0] in_operand,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    import bitcnt_pkg::*;

    localparam int CNT_W = $clog2(DATA_W) + 1;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } state_t;

    state_t  st_d, st_q;
    cnt_op_t op;
    logic [DATA_W-1:0] scan_vec, ones_vec;
    logic [CNT_W-1:0]  scan_cnt, ones_cnt;

    assign op = cnt_op_t'(in_op);

    bitcnt_prep #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_prep (
        .operand  (in_operand),
        .word     (op.word),
        .reverse  (op.kind == KIND_LEAD),
        .scan_vec (scan_vec),
        .ones_vec (ones_vec)
    );

    bitcnt_tzc #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tzc (
        .vec   (scan_vec),
        .count (scan_cnt)
    );

    bitcnt_popc #(.DATA_W(DATA_W), .GROUP_W(GROUP_W), .CNT_W(CNT_W)) u_popc (
        .vec   (ones_vec),
        .count (ones_cnt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            unique case (op.kind)
                KIND_LEAD, KIND_TRAIL: st_d.res = DATA_W'(scan_cnt);
                KIND_ONES:             st_d.res = DATA_W'(ones_cnt);
                default:               st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_result = st_q.res;
endmodule

// File: rtl/bitcnt_unit_chk.sv
module bitcnt_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic [DATA_W-1:0] in_operand,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);
    localparam int CNT_W = $clog2(DATA_W) + 1;

    assert_strobe_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_strobe_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_result[DATA_W-1:CNT_W] == '0);

    assert_full_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_result <= DATA_W'(DATA_W));

    assert_word_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[2]) |=> out_result <= DATA_W'(DATA_W / 2));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));

    assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1:0] == 2'b11) |=> out_result == '0);

    assert_empty_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_operand == '0 && in_op[1] == 1'b0 && !in_op[2])
        |=> out_result == DATA_W'(DATA_W));
endmodule

bind bitcnt_unit bitcnt_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_operand (in_operand),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/bitcnt_unit_bench.sv
`timescale 1ns/1ps
module bitcnt_unit_bench;
    localparam int NV = 20;

    localparam logic [2:0] V_OP [NV] = '{
        3'b000, 3'b000, 3'b000, 3'b100, 3'b100,
        3'b001, 3'b001, 3'b001, 3'b101, 3'b101,
        3'b010, 3'b010, 3'b110, 3'b110, 3'b000,
        3'b100, 3'b001, 3'b011, 3'b111, 3'b010
    };
    localparam logic [63:0] V_IN [NV] = '{
        64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, 64'h0000_0100_0000_0000,
        64'hFFFF_FFFF_0000_8000, 64'h0000_0000_8000_0000,
        64'h8000_0000_0000_0000, 64'h0000_0000_0001_0000, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0001_0000_0000, 64'h0000_0000_4000_0000,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0F0F_0000_0000_0003, 64'hFFFF_FFFF_0000_00FF,
        64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0000,
        64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_1234,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000
    };
    localparam logic [63:0] V_EXP [NV] = '{
        64'd63, 64'd0, 64'd23, 64'd16, 64'd0,
        64'd63, 64'd16, 64'd0, 64'd32, 64'd30,
        64'd64, 64'd10, 64'd8, 64'd32, 64'd64,
        64'd32, 64'd64, 64'd0, 64'd0, 64'd0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = 3'b000;
    logic [63:0] in_operand = '0;
    logic        out_valid;
    logic [63:0] out_result;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    bitcnt_unit u_bitcnt_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_operand (in_operand),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'b000:         return "R1";
            3'b100:         return "R2";
            3'b001:         return "R3";
            3'b101:         return "R4";
            3'b010, 3'b110: return "R5";
            default:        return "R11";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [63:0] val);
        @(negedge clk);
        in_valid   = 1'b1;
        in_op      = op;
        in_operand = val;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #4_000_000;
        checks++;
        fails++;
        $display("FAIL R9 watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset valid", {63'd0, out_valid}, 64'd0);
        check("R9 reset result", out_result, 64'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            run_op(V_OP[k], V_IN[k]);
            check(req_of(V_OP[k]), out_result, V_EXP[k]);
            check("R9 strobe", {63'd0, out_valid}, 64'd1);
            check("R6 upper zero", {out_result[63:7], 7'd0}, 64'd0);
        end

        // R7: all-zero examined bits, word forms with noisy upper half too
        run_op(3'b101, 64'hABCD_0000_0000_0000);
        check("R7 ctzw empty", out_result, 64'd32);
        run_op(3'b100, 64'h0000_0000_0000_0000);
        check("R7 clzw empty", out_result, 64'd32);

        // R8: same low half, different upper half, each word form
        for (int w = 0; w < 3; w++) begin
            logic [63:0] r_a;
            run_op({1'b1, 2'(w)}, 64'h0000_0000_0F00_0F00);
            r_a = out_result;
            run_op({1'b1, 2'(w)}, 64'hF0F0_5A5A_0F00_0F00);
            check("R8 upper ignored", out_result, r_a);
        end

        // R9/R10: no request -> strobe low, result held while operand moves
        run_op(3'b010, 64'h0000_0000_0000_00FF);
        check("R5 cpop", out_result, 64'd8);
        @(negedge clk);
        in_op      = 3'b000;
        in_operand = 64'h0000_0000_0000_0001;
        @(negedge clk);
        check("R9 idle strobe", {63'd0, out_valid}, 64'd0);
        check("R10 held", out_result, 64'd8);
        in_operand = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        check("R10 still held", out_result, 64'd8);

        // R9: back-to-back requests, one result per edge
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'b001; in_operand = 64'h0000_0000_0000_0100;
        @(negedge clk);
        check("R3 pipelined", out_result, 64'd8);
        in_op = 3'b010; in_operand = 64'h0000_0000_0000_0007;
        @(negedge clk);
        check("R5 pipelined", out_result, 64'd3);
        check("R9 pipelined strobe", {63'd0, out_valid}, 64'd1);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 strobe falls", {63'd0, out_valid}, 64'd0);

        finish_run();
    end
endmodule